// File: doc/BRIEF.md
# Wiper Position Register with One-Hot Tap Select

This block holds the volatile position of a digitally controlled potentiometer wiper and turns it into the enables for the tap switches along a resistor string. The position can change in four ways. A power-on recall copies the stored default value into it. A parallel transfer copies the value of a selected stored register. A serial write loads a byte that has arrived over the bus. A step pulse moves the wiper one tap at a time. The resistor string and the bus front end are outside this block: it receives strobes with their data bytes and drives the switch enables.

After reset the block is in state `ST_AWAIT_RECALL`. In this state the position is not yet meaningful, so every switch is off and only a recall is accepted. The transition `RECALL_ACCEPT` takes the block into `ST_TRACK`, where it accepts every source. In `ST_TRACK` the transitions are `LOAD_RECALL`, `LOAD_XFER`, `LOAD_WRITE`, `STEP_MOVE` and `HOLD`, all of which stay in `ST_TRACK`. The switch enables are registered from the next-position value, so the position read-back and the single active switch change on the same clock edge.

Top module: `pot_wiper_ctrl`

## Requirements
- R1: `tap_en` never has more than one bit set; in the tracking state it has exactly one bit set.
- R2: In the tracking state, the set bit of `tap_en` has the index `wiper_pos`: position 0x00 enables bit 0, which is the low-terminal switch, and 0xFF enables bit 255, which is the high-terminal switch. Both outputs update on the same clock edge.
- R3: After reset `wiper_pos` is 0x00 and `tap_en` is all zero. Until the first recall, a transfer, a write or a step leaves both outputs unchanged.
- R4: A `recall_req` sampled on a clock edge loads `recall_data` on that edge, in either state, and enters or stays in the tracking state.
- R5: A `xfer_stb` in the tracking state loads `xfer_data`.
- R6: A `wr_stb` in the tracking state loads `wr_data`.
- R7: `step_up` on its own raises the position by one, and holds it at 0xFF when it is already there.
- R8: `step_dn` on its own lowers the position by one, and holds it at 0x00 when it is already there. When `step_up` and `step_dn` are both high, the position does not change.
- R9: When several sources are active in one cycle, the winner is decided in this order: recall, then transfer, then write, then step.
- R10: In a cycle with no strobe and no single step pulse, both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recall_req | input | 1 | Power-on recall strobe |
| recall_data | input | 8 | Default value that the recall loads |
| xfer_stb | input | 1 | Parallel transfer strobe |
| xfer_data | input | 8 | Value of the selected stored register |
| wr_stb | input | 1 | Serial write strobe |
| wr_data | input | 8 | Byte received from the bus |
| step_up | input | 1 | Step one tap toward the high terminal |
| step_dn | input | 1 | Step one tap toward the low terminal |
| wiper_pos | output | 8 | Current position, for read-back |
| tap_en | output | 256 | One-hot switch enables, bit 0 at the low terminal |

## Verification
The hardest situations to reach from the ports are the window before the first recall and the cycles in which several sources collide. The stimulus reaches the first by applying writes, transfers and steps straight after reset, before any recall has been issued. It reaches the second by raising every strobe together with distinct data bytes, then removing the winning source one at a time. The saturation corners are reached by writing a position next to an end and then stepping past that end, and by walking the full range one step at a time from 0x00. Every position is also loaded by a write and by a transfer, and each time the whole 256-bit enable vector is compared with the expected single set bit.

// File: rtl/pot_wiper_pkg.sv
package pot_wiper_pkg;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_RECALL,
        SRC_XFER,
        SRC_WRITE,
        SRC_STEP
    } src_e;

    typedef enum logic {
        ST_AWAIT_RECALL,
        ST_TRACK
    } state_e;

endpackage

// File: rtl/pot_src_arbiter.sv
module pot_src_arbiter
    import pot_wiper_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic             recall_req,
    input  logic [POS_W-1:0] recall_data,
    input  logic             xfer_stb,
    input  logic [POS_W-1:0] xfer_data,
    input  logic             wr_stb,
    input  logic [POS_W-1:0] wr_data,
    input  logic             step_up,
    input  logic             step_dn,
    output src_e             sel,
    output logic [POS_W-1:0] load_val,
    output logic             step_dir_up
);

    logic step_single;

    // A step counts only when exactly one direction is requested
    assign step_single = step_up ^ step_dn;
    assign step_dir_up = step_up;

    always_comb begin
        sel      = SRC_NONE;
        load_val = '0;
        if (recall_req) begin
            sel      = SRC_RECALL;
            load_val = recall_data;
        end else if (xfer_stb) begin
            sel      = SRC_XFER;
            load_val = xfer_data;
        end else if (wr_stb) begin
            sel      = SRC_WRITE;
            load_val = wr_data;
        end else if (step_single) begin
            sel      = SRC_STEP;
        end
    end

endmodule

// File: rtl/pot_position_fsm.sv
module pot_position_fsm
    import pot_wiper_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  src_e             sel,
    input  logic [POS_W-1:0] load_val,
    input  logic             step_dir_up,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_d,
    output logic             track_d
);

    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] POS_MIN = '0;

    state_e state_q;
    state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_AWAIT_RECALL;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // Next state and next position
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_AWAIT_RECALL: begin
                // RECALL_ACCEPT: every other source is ignored here
                if (sel == SRC_RECALL) begin
                    state_d = ST_TRACK;
                    pos_d   = load_val;
                end
            end
            ST_TRACK: begin
                unique case (sel)
                    SRC_RECALL, SRC_XFER, SRC_WRITE: begin
                        pos_d = load_val;
                    end
                    SRC_STEP: begin
                        if (step_dir_up) begin
                            pos_d = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
                        end else begin
                            pos_d = (pos_q == POS_MIN) ? pos_q : pos_q - 1'b1;
                        end
                    end
                    default: begin
                        pos_d = pos_q;
                    end
                endcase
            end
            default: begin
                state_d = ST_AWAIT_RECALL;
            end
        endcase
    end

    assign track_d = (state_d == ST_TRACK);

endmodule

// File: rtl/pot_tap_decoder.sv
module pot_tap_decoder #(
    parameter int POS_W = 8,
    localparam int TAPS = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_d,
    input  logic             track_d,
    output logic [TAPS-1:0]  tap_q
);

    // One flop per switch, loaded from the next position value
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tap_q[i] <= 1'b0;
            end else begin
                tap_q[i] <= track_d && (pos_d == POS_W'(i));
            end
        end
    end

endmodule

// File: rtl/pot_wiper_ctrl.sv
module pot_wiper_ctrl
    import pot_wiper_pkg::*;
#(
    parameter int POS_W = 8,
    localparam int TAPS = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             recall_req,
    input  logic [POS_W-1:0] recall_data,
    input  logic             xfer_stb,
    input  logic [POS_W-1:0] xfer_data,
    input  logic             wr_stb,
    input  logic [POS_W-1:0] wr_data,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [POS_W-1:0] wiper_pos,
    output logic [TAPS-1:0]  tap_en
);

    src_e             sel;
    logic [POS_W-1:0] load_val;
    logic             step_dir_up;
    logic [POS_W-1:0] pos_d;
    logic             track_d;

    pot_src_arbiter #(.POS_W(POS_W)) u_arb (
        .recall_req  (recall_req),
        .recall_data (recall_data),
        .xfer_stb    (xfer_stb),
        .xfer_data   (xfer_data),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .step_up     (step_up),
        .step_dn     (step_dn),
        .sel         (sel),
        .load_val    (load_val),
        .step_dir_up (step_dir_up)
    );

    pot_position_fsm #(.POS_W(POS_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .load_val    (load_val),
        .step_dir_up (step_dir_up),
        .pos_q       (wiper_pos),
        .pos_d       (pos_d),
        .track_d     (track_d)
    );

    pot_tap_decoder #(.POS_W(POS_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_d   (pos_d),
        .track_d (track_d),
        .tap_q   (tap_en)
    );

endmodule

// File: rtl/pot_wiper_ctrl_chk.sv
module pot_wiper_ctrl_chk #(
    parameter int POS_W = 8,
    localparam int TAPS = 1 << POS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             recall_req,
    input logic [POS_W-1:0] recall_data,
    input logic             xfer_stb,
    input logic [POS_W-1:0] xfer_data,
    input logic             wr_stb,
    input logic [POS_W-1:0] wr_data,
    input logic             step_up,
    input logic             step_dn,
    input logic [POS_W-1:0] wiper_pos,
    input logic [TAPS-1:0]  tap_en
);

    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    logic tracking;
    logic no_load;
    assign tracking = (tap_en != '0);
    assign no_load  = !recall_req && !xfer_stb && !wr_stb;

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tap_en)) else $error("tap enables not one-hot"); // R1

    AST_TAP_MATCHES_POS: assert property (@(posedge clk) disable iff (!rst_n)
        tracking |-> (tap_en == (TAPS'(1) << wiper_pos))) else $error("tap index differs from position"); // R2

    AST_LOCKED_BEFORE_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!tracking && !recall_req) |=> (!tracking && $stable(wiper_pos))) else $error("state changed before recall"); // R3

    AST_RECALL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> (tracking && wiper_pos == $past(recall_data))) else $error("recall did not load"); // R4

    AST_XFER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && !recall_req && xfer_stb) |=> (wiper_pos == $past(xfer_data))) else $error("transfer did not load"); // R5

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && !recall_req && !xfer_stb && wr_stb) |=> (wiper_pos == $past(wr_data))) else $error("write did not load"); // R6

    AST_UP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && no_load && step_up && !step_dn && wiper_pos == POS_MAX) |=> (wiper_pos == POS_MAX)) else $error("step up wrapped"); // R7

    AST_DN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && no_load && step_dn && !step_up && wiper_pos == '0) |=> (wiper_pos == '0)) else $error("step down wrapped"); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (no_load && !(step_up ^ step_dn)) |=> ($stable(wiper_pos) && $stable(tap_en))) else $error("idle cycle changed outputs"); // R10

endmodule

bind pot_wiper_ctrl pot_wiper_ctrl_chk #(.POS_W(POS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .recall_req  (recall_req),
    .recall_data (recall_data),
    .xfer_stb    (xfer_stb),
    .xfer_data   (xfer_data),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .step_up     (step_up),
    .step_dn     (step_dn),
    .wiper_pos   (wiper_pos),
    .tap_en      (tap_en)
);

// File: tb/sim_pot_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_pot_wiper_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         recall_req = 1'b0;
    logic [7:0]   recall_data = '0;
    logic         xfer_stb = 1'b0;
    logic [7:0]   xfer_data = '0;
    logic         wr_stb = 1'b0;
    logic [7:0]   wr_data = '0;
    logic         step_up = 1'b0;
    logic         step_dn = 1'b0;
    logic [7:0]   wiper_pos;
    logic [255:0] tap_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pot_wiper_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .recall_req  (recall_req),
        .recall_data (recall_data),
        .xfer_stb    (xfer_stb),
        .xfer_data   (xfer_data),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .step_up     (step_up),
        .step_dn     (step_dn),
        .wiper_pos   (wiper_pos),
        .tap_en      (tap_en)
    );

    function automatic logic [255:0] onehot(input logic [7:0] v);
        return 256'(1) << v;
    endfunction

    task automatic chk(input string req, input logic [7:0] exp_pos, input logic [255:0] exp_tap);
        checks++;
        if (wiper_pos !== exp_pos || tap_en !== exp_tap) begin
            errors++;
            $display("FAIL %s: wiper_pos=%02h expected %02h, tap_en=%064h expected %064h",
                     req, wiper_pos, exp_pos, tap_en, exp_tap);
        end
    endtask

    // Called at a falling edge: drive for one rising edge, release, return at the next falling edge
    task automatic apply(input logic r, input logic [7:0] rd,
                         input logic x, input logic [7:0] xd,
                         input logic w, input logic [7:0] wd,
                         input logic u, input logic d);
        recall_req = r; recall_data = rd;
        xfer_stb = x;   xfer_data = xd;
        wr_stb = w;     wr_data = wd;
        step_up = u;    step_dn = d;
        @(posedge clk);
        @(negedge clk);
        recall_req = 1'b0; xfer_stb = 1'b0; wr_stb = 1'b0;
        step_up = 1'b0;    step_dn = 1'b0;
    endtask

    initial begin
        logic [7:0] model;
        repeat (3) @(negedge clk);
        chk("R3 reset state", 8'h00, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 after reset release", 8'h00, '0);

        // Sources other than recall are ignored before the first recall
        apply(0, 8'h00, 0, 8'h00, 1, 8'h55, 0, 0);
        chk("R3 write before recall", 8'h00, '0);
        apply(0, 8'h00, 1, 8'h33, 0, 8'h00, 0, 0);
        chk("R3 transfer before recall", 8'h00, '0);
        apply(0, 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
        chk("R3 step before recall", 8'h00, '0);

        apply(1, 8'h80, 0, 8'h00, 0, 8'h00, 0, 0);
        chk("R4 first recall", 8'h80, onehot(8'h80));

        // Serial write over every position, also covering R1 and R2
        for (int v = 0; v < 256; v++) begin
            apply(0, 8'h00, 0, 8'h00, 1, 8'(v), 0, 0);
            chk("R6 R1 R2 write sweep", 8'(v), onehot(8'(v)));
        end

        // Parallel transfer over every position, in a scrambled order
        for (int v = 0; v < 256; v++) begin
            apply(0, 8'h00, 1, 8'(v) ^ 8'hA5, 0, 8'h00, 0, 0);
            chk("R5 R2 transfer sweep", 8'(v) ^ 8'hA5, onehot(8'(v) ^ 8'hA5));
        end

        // Upward saturation at the high end
        apply(0, 8'h00, 0, 8'h00, 1, 8'hFD, 0, 0);
        model = 8'hFD;
        for (int k = 0; k < 4; k++) begin
            apply(0, 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
            model = (model == 8'hFF) ? model : model + 8'd1;
            chk("R7 step up near top", model, onehot(model));
        end

        // Downward saturation at the low end
        apply(0, 8'h00, 0, 8'h00, 1, 8'h02, 0, 0);
        model = 8'h02;
        for (int k = 0; k < 4; k++) begin
            apply(0, 8'h00, 0, 8'h00, 0, 8'h00, 0, 1);
            model = (model == 8'h00) ? model : model - 8'd1;
            chk("R8 step down near bottom", model, onehot(model));
        end

        apply(0, 8'h00, 0, 8'h00, 1, 8'h40, 0, 0);
        apply(0, 8'h00, 0, 8'h00, 0, 8'h00, 1, 1);
        chk("R8 both step pulses", 8'h40, onehot(8'h40));

        // Full upward walk from the low terminal
        apply(0, 8'h00, 0, 8'h00, 1, 8'h00, 0, 0);
        for (int k = 1; k <= 257; k++) begin
            apply(0, 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
            model = (k > 255) ? 8'hFF : 8'(k);
            chk("R7 R2 upward walk", model, onehot(model));
        end

        // Full downward walk from the high terminal
        for (int k = 1; k <= 257; k++) begin
            apply(0, 8'h00, 0, 8'h00, 0, 8'h00, 0, 1);
            model = (k > 255) ? 8'h00 : 8'(255 - k);
            chk("R8 R2 downward walk", model, onehot(model));
        end

        // Priority between simultaneous sources
        apply(1, 8'h11, 1, 8'h22, 1, 8'h33, 1, 0);
        chk("R9 recall wins", 8'h11, onehot(8'h11));
        apply(0, 8'h00, 1, 8'h22, 1, 8'h33, 1, 0);
        chk("R9 transfer beats write and step", 8'h22, onehot(8'h22));
        apply(0, 8'h00, 0, 8'h00, 1, 8'h33, 0, 1);
        chk("R9 write beats step", 8'h33, onehot(8'h33));

        // Idle cycles hold
        repeat (5) @(negedge clk);
        chk("R10 idle hold", 8'h33, onehot(8'h33));

        apply(1, 8'hC7, 0, 8'h00, 0, 8'h00, 0, 0);
        chk("R4 recall while tracking", 8'hC7, onehot(8'hC7));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R10 run): actual still running, expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule